// File: doc/BRIEF.md
# Converter serial result port

This block is the digital output side of a sampling converter. It keeps a busy flag that is set while a conversion runs. It shows that flag on the serial data line as a status bit that reads 1 while converting and 0 once a result waits. When the converter core signals completion, the block holds the result word. A following serial frame shifts the word out, most significant bit first, one bit per falling edge of the serial clock.

The serial clock either comes from outside or is generated here from the system clock by a run-time divider. The source is chosen from the level of the serial clock pin at two moments. If the pin sits low at the first clock after reset, the block stays on the outside clock until the next reset. Otherwise the level at each chip-select falling edge picks the source for that frame: high selects the internal clock and low selects the outside clock. The data line floats while chip select is high. A frame cut short by chip select rising leaves the result in place, and the next frame starts again from the status bit.

The outside serial clock and chip select are taken to be synchronous to the system clock and much slower than it. Each of their edges is seen one system clock later.

Top module: `serial_result_port`

## Requirements
- R1: While cs_n is high, sdo_oe and sck_oe are both 0.
- R2: While a conversion is running (from reset, and again after a completed frame), sdo reads 1 whenever cs_n is low, and falling serial clock edges do not change it.
- R3: A one-cycle conv_done pulse during a conversion captures data. From the next cycle, sdo with cs_n low reads 0, which is the status bit.
- R4: The frame is 24 bits, sent most significant bit first. Frame bit 23 is the status bit (0), and frame bits 22..0 are data[22..0]. After k falling serial clock edges (k = 0..23), sdo shows frame bit 23-k.
- R5: On the 24th falling edge, sdo returns to 1 and a new conversion is considered running. Further edges leave sdo at 1 until the next conv_done.
- R6: If sck_in is low at the first clock after reset, the outside clock is used until the next reset. sck_oe then stays 0 even when sck_in is high at a chip-select falling edge.
- R7: Otherwise, sck_in high at a chip-select falling edge selects the internal clock. From the next cycle, sck_oe is 1 while cs_n stays low, and sck_out is held low while a conversion runs.
- R8: sck_in low at a chip-select falling edge selects the outside clock for that frame, and sck_oe stays 0.
- R9: The internal clock toggles every max(sck_div,1) system clocks. It starts low and stops low after the 24th falling edge.
- R10: If cs_n rises before the 24th falling edge, the block stays in the result-waiting state. The next frame restarts at frame bit 23 with the same data.
- R11: A conv_done pulse while a result is waiting is ignored, and the held data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck_in | input | 1 | Level seen on the serial clock pin |
| sck_div | input | 8 | Internal clock half period in system clocks (0 acts as 1) |
| conv_done | input | 1 | One-cycle pulse when the converter core finishes |
| data | input | 23 | Conversion result, valid with conv_done |
| sdo | output | 1 | Serial data and status bit |
| sdo_oe | output | 1 | Output enable for sdo |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Output enable for sck_out |

## Verification
The hardest states to reach from the ports are those that depend on history rather than on the current inputs. These are:
- a frame aborted part way and then read again;
- a conv_done pulse arriving while a result is still waiting;
- the lock onto the outside clock, which needs a second reset released with sck_in low.

Directed steps set each of these up explicitly. The bench orders the chip-select and clock levels so that the mode sample and the first edge never land in the same cycle. Random rounds then mix clock source, divider value, extra conv_done pulses and abort points, and a bench-side busy model carries the held word across rounds.

// File: rtl/srp_pkg.sv
// Shared types for the serial result port.
package srp_pkg;

    // Serial clock source used for the current frame.
    typedef enum logic {
        CLK_EXT = 1'b0,
        CLK_INT = 1'b1
    } clk_src_e;

endpackage

// File: rtl/srp_clk_select.sv
// Chooses the serial clock source.
// Samples sck_in once at the first clock after reset: a low level locks the
// outside clock until reset. Otherwise the sck_in level at each cs_n falling
// edge picks the source for that frame.
// Assumes cs_n and sck_in are already synchronous to clk.
module srp_clk_select
    import srp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sck_in,
    output clk_src_e src,
    output logic     locked
);

    logic por_done;
    logic cs_q;

    // Power-up sample, cs_n edge history and per-frame source choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_done <= 1'b0;
            locked   <= 1'b0;
            cs_q     <= 1'b1;
            src      <= CLK_EXT;
        end else begin
            cs_q <= cs_n;
            if (!por_done) begin
                por_done <= 1'b1;
                locked   <= ~sck_in;
            end else if (!locked && cs_q && !cs_n) begin
                src <= sck_in ? CLK_INT : CLK_EXT;
            end
        end
    end

endmodule

// File: rtl/srp_sck_gen.sv
// Internal serial clock generator.
// While run is high it toggles sck every max(half,1) system clocks, starting
// low. When run drops, it returns low at once and restarts from zero.
// fall_evt marks the cycle in which sck is about to go low.
module srp_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             wrap;

    // Clamp a zero divider to one so the ratio is never below two.
    always_comb begin
        half_eff = (half == '0) ? DIV_W'(1) : half;
    end

    assign wrap     = (cnt == half_eff - DIV_W'(1));
    assign fall_evt = run && sck && wrap;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/srp_frame.sv
// Conversion status and frame sequencer.
// Holds the busy flag and the captured result, and steps a bit index on each
// shift event. It presents the status bit or the indexed result bit.
// Assumes shift_evt is a single-cycle pulse per falling serial clock edge.
module srp_frame #(
    parameter  int DATA_W  = 23,
    localparam int FRAME_W = DATA_W + 1,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] data,
    input  logic              shift_evt,
    output logic              busy,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sdo_bit
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [DATA_W-1:0]  hold;
    logic [FRAME_W-1:0] frame_vec;

    assign frame_vec = {1'b0, hold};

    // Status while converting, otherwise the frame bit at the current index.
    always_comb begin
        sdo_bit = busy ? 1'b1 : frame_vec[LAST - bit_cnt];
    end

    // Capture on completion, abort on cs_n high, step on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            hold    <= '0;
            bit_cnt <= '0;
        end else if (busy) begin
            if (conv_done) begin
                busy    <= 1'b0;
                hold    <= data;
                bit_cnt <= '0;
            end
        end else if (cs_n) begin
            bit_cnt <= '0;
        end else if (shift_evt) begin
            if (bit_cnt == LAST) begin
                busy    <= 1'b1;
                bit_cnt <= '0;
            end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/serial_result_port.sv
// Serial result port of a sampling converter.
// Shows conversion status on sdo, serialises the held result on falling
// serial clock edges, and picks an internal or outside serial clock.
// Assumes cs_n and sck_in are synchronous to clk and far slower than it.
module serial_result_port
    import srp_pkg::*;
#(
    parameter int DATA_W = 23,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_in,
    input  logic [DIV_W-1:0]  sck_div,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sck_out,
    output logic              sck_oe
);

    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);

    clk_src_e         src;
    logic             locked;
    logic             busy;
    logic [CNT_W-1:0] bit_cnt;
    logic             sdo_bit;
    logic             sck_q;
    logic             ext_fall;
    logic             int_fall;
    logic             run;
    logic             shift_evt;

    // Previous outside clock level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_in;
        end
    end

    assign ext_fall  = sck_q & ~sck_in;
    assign run       = (src == CLK_INT) && !cs_n && !busy;
    assign shift_evt = (src == CLK_INT) ? int_fall : ext_fall;

    srp_clk_select i_clk_select (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck_in (sck_in),
        .src    (src),
        .locked (locked)
    );

    srp_sck_gen #(.DIV_W(DIV_W)) i_sck_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (sck_div),
        .sck      (sck_out),
        .fall_evt (int_fall)
    );

    srp_frame #(.DATA_W(DATA_W)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .conv_done (conv_done),
        .data      (data),
        .shift_evt (shift_evt),
        .busy      (busy),
        .bit_cnt   (bit_cnt),
        .sdo_bit   (sdo_bit)
    );

    // Pin drivers: sdo follows chip select, sck drive only in internal mode.
    always_comb begin
        sdo    = sdo_bit;
        sdo_oe = !cs_n;
        sck_oe = (src == CLK_INT) && !cs_n;
    end

endmodule

// File: rtl/srp_checker.sv
// Timing properties of the serial result port, bound into the top module.
module srp_checker
    import srp_pkg::*;
#(
    parameter  int DATA_W  = 23,
    localparam int FRAME_W = DATA_W + 1,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             conv_done,
    input logic             sdo,
    input logic             sck_out,
    input logic             busy,
    input logic [CNT_W-1:0] bit_cnt,
    input clk_src_e         src,
    input logic             shift_evt,
    input logic             locked
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> (!busy && bit_cnt == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && shift_evt && bit_cnt != LAST)
        |=> (bit_cnt == $past(bit_cnt) + CNT_W'(1)));

    p_frame_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && shift_evt && bit_cnt == LAST) |=> (busy && sdo));

    p_lock_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (src == CLK_EXT));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == CLK_INT && busy) |-> !sck_out);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cs_n) |=> (!busy && bit_cnt == '0));

    p_keep_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_done && !shift_evt) |=> !busy);

endmodule

bind serial_result_port srp_checker #(.DATA_W(DATA_W)) i_srp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .conv_done (conv_done),
    .sdo       (sdo),
    .sck_out   (sck_out),
    .busy      (busy),
    .bit_cnt   (bit_cnt),
    .src       (src),
    .shift_evt (shift_evt),
    .locked    (locked)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sck_in;
    logic [7:0]  sck_div;
    logic        conv_done;
    logic [22:0] data;
    logic        sdo;
    logic        sdo_oe;
    logic        sck_out;
    logic        sck_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_result_port i_serial_result_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_in    (sck_in),
        .sck_div   (sck_div),
        .conv_done (conv_done),
        .data      (data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .sck_out   (sck_out),
        .sck_oe    (sck_oe)
    );

    // Expected sdo after k falling edges of a frame carrying d.
    function automatic logic exp_bit(logic [22:0] d, int k);
        logic [23:0] f;
        f = {1'b0, d};
        if (k >= 24) return 1'b1;
        return f[23-k];
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_done(logic [22:0] d);
        data      = d;
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
    endtask

    // Lower chip select with sck_in set one cycle earlier to the wanted level.
    task automatic select_src(logic want_int);
        sck_in = want_int;
        tick();
        cs_n = 1'b0;
        tick();
    endtask

    task automatic ext_fall();
        sck_in = 1'b1;
        tick();
        sck_in = 1'b0;
        tick();
    endtask

    task automatic ext_read(logic [22:0] d, int n, string tag);
        for (int k = 1; k <= n; k++) begin
            ext_fall();
            chk((k == 24) ? "R5 frame end" : tag, sdo, exp_bit(d, k));
        end
    endtask

    task automatic int_read(logic [22:0] d, int half);
        int   falls;
        int   since;
        int   guard;
        bit   seen;
        logic prev;
        falls = 0;
        since = 0;
        guard = 0;
        seen  = 1'b0;
        prev  = sck_out;
        while (falls < 24 && guard < 4000) begin
            tick();
            guard++;
            since++;
            if (sck_out !== prev) begin
                if (seen) chk_int("R9 half period", since, half);
                seen  = 1'b1;
                since = 0;
                if (prev === 1'b1) begin
                    falls++;
                    chk((falls == 24) ? "R5 frame end" : "R4 internal bit",
                        sdo, exp_bit(d, falls));
                end
                prev = sck_out;
            end
        end
        chk_int("R9 fall count", falls, 24);
        repeat (3*half + 2) begin
            tick();
            chk("R9 stops low", sck_out, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [22:0] cur_d;
        bit          busy_m;
        int          seed;
        seed      = $urandom(32'h5EED1234);
        rst_n     = 1'b0;
        cs_n      = 1'b1;
        sck_in    = 1'b1;
        sck_div   = 8'd2;
        conv_done = 1'b0;
        data      = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset sdo_oe", sdo_oe, 1'b0);
        chk("R1 reset sck_oe", sck_oe, 1'b0);

        // Outside clock frame while converting.
        select_src(1'b0);
        chk("R1 sdo driven when selected", sdo_oe, 1'b1);
        chk("R8 outside clock no drive", sck_oe, 1'b0);
        chk("R2 status high after reset", sdo, 1'b1);
        ext_fall();
        ext_fall();
        chk("R2 edges ignored while converting", sdo, 1'b1);

        // Capture, ignored second completion, full readout.
        cur_d = 23'h5A3C71;
        pulse_done(cur_d);
        chk("R3 status low after capture", sdo, 1'b0);
        pulse_done(23'h0F0F0F);
        chk("R11 status unchanged", sdo, 1'b0);
        ext_read(cur_d, 24, "R11 held data bit");
        ext_fall();
        chk("R5 stays high after frame", sdo, 1'b1);

        // Abort after five bits and read again.
        cur_d = 23'h2B6D19;
        pulse_done(cur_d);
        ext_read(cur_d, 5, "R4 outside bit");
        cs_n = 1'b1;
        tick();
        chk("R1 sdo floats on abort", sdo_oe, 1'b0);
        select_src(1'b0);
        chk("R10 restart at status bit", sdo, 1'b0);
        ext_read(cur_d, 24, "R10 same data after abort");

        // Internal clock, result ready before chip select.
        cs_n = 1'b1;
        tick();
        cur_d = 23'h7FFFFE;
        pulse_done(cur_d);
        sck_div = 8'd2;
        select_src(1'b1);
        chk("R7 internal drive", sck_oe, 1'b1);
        chk("R4 status bit first", sdo, 1'b0);
        int_read(cur_d, 2);
        chk("R7 drive held after frame", sck_oe, 1'b1);

        // Internal clock with chip select low while converting.
        cs_n = 1'b1;
        tick();
        select_src(1'b1);
        chk("R2 status high internal", sdo, 1'b1);
        repeat (6) begin
            tick();
            chk("R7 sck low while converting", sck_out, 1'b0);
            chk("R7 sck driven while converting", sck_oe, 1'b1);
        end
        sck_div = 8'd0;
        cur_d = 23'h000001;
        pulse_done(cur_d);
        chk("R3 status low internal", sdo, 1'b0);
        int_read(cur_d, 1);

        // Random rounds.
        busy_m = 1'b1;
        for (int r = 0; r < 16; r++) begin
            logic want_int;
            int   half;
            int   n;
            cs_n = 1'b1;
            tick();
            chk("R1 floats between frames", sdo_oe | sck_oe, 1'b0);
            if (busy_m) begin
                cur_d = 23'($urandom);
                pulse_done(cur_d);
                busy_m = 1'b0;
            end
            if ($urandom % 3 == 0) pulse_done(23'($urandom));
            want_int = 1'($urandom);
            sck_div  = 8'($urandom % 5);
            half     = (sck_div == 0) ? 1 : int'(sck_div);
            select_src(want_int);
            chk(want_int ? "R7 random select" : "R8 random select", sck_oe, want_int);
            chk("R3 random status low", sdo, 1'b0);
            if (want_int) begin
                int_read(cur_d, half);
                busy_m = 1'b1;
            end else begin
                n = 1 + int'($urandom % 24);
                ext_read(cur_d, n, "R4 random bit");
                if (n == 24) busy_m = 1'b1;
            end
        end

        // Reset released with sck_in low locks the outside clock.
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sck_in = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        select_src(1'b1);
        chk("R6 locked no drive", sck_oe, 1'b0);
        chk("R2 status high after second reset", sdo, 1'b1);
        cur_d = 23'h4C2E95;
        pulse_done(cur_d);
        ext_read(cur_d, 24, "R6 outside clock readout");
        cs_n = 1'b1;
        tick();
        select_src(1'b1);
        chk("R6 still locked", sck_oe, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule